// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a three-wire serial slave for a bank of 8-bit control registers. A host drives a serial clock, a serial data line and an enable strobe. Each frame is fourteen bits long: a 6-bit address, then 8 data bits, both sent most significant bit first. Address bit 4 selects the operation. When it is clear, a pulse on the enable line stores the data byte in the addressed register. When it is set, the frame is a read request: its data bits are ignored, and the register at the same address with bit 4 cleared is shifted out on the serial output.

The read data changes on falling serial-clock edges. The host can therefore clock the next frame in while it collects the previous answer. The serial output shares a pad with a data-bus bit, so the block also provides a drive enable that follows the active-low output enable. All serial inputs are sampled by the block's system clock, and edges are found by comparing each input with its value one system clock earlier. Every register drives a flat configuration bus for the surrounding logic.

Top module: `sras_top`

## Requirements
- R1: After reset, every register on `cfg_regs` reads 0x00 and `sdo` is 0.
- R2: A frame of exactly 14 rising `sck` edges, with address bit 4 clear, is committed by a rising edge on `sen`. The byte goes to register index {a5,a3,a2,a1,a0}, which is byte lane index*8 of `cfg_regs`. The new value appears in the system-clock cycle after the one in which `sen` is first seen high.
- R3: `sdi` is sampled only on rising `sck` edges. A change of `sdi` between a rising edge and the following falling edge has no effect.
- R4: A `sen` rising edge after any count of rising `sck` edges other than 14 discards the frame and leaves all registers unchanged. Every `sen` rising edge restarts the bit count at zero.
- R5: A frame with address bit 4 set changes no register, whatever its 8 data bits are.
- R6: A committed read frame loads the register at index {a5,a3,a2,a1,a0}. Its bit 7 is on `sdo` from the cycle after the commit.
- R7: Each later falling `sck` edge moves `sdo` to the next lower bit. After the eighth falling edge, `sdo` returns to 0.
- R8: Frames shifted in while a read is still being output are received normally, including writes.
- R9: `sdo_oe` is 1 exactly while `oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| sdi | input | 1 | Serial data in |
| sen | input | 1 | Commit strobe, acts on its rising edge |
| oe_n | input | 1 | Active-low output enable of the shared pad |
| sdo | output | 1 | Serial read data, 0 when idle |
| sdo_oe | output | 1 | Pad drive enable |
| cfg_regs | output | NUM_REGS*8 | Register contents, register i in bits [8i+7:8i] |

## Verification
Each edge on `sck` or `sen` is detected in the first clk cycle in which the new level is seen, and its effect is registered at that same clock edge. A write is therefore visible on `cfg_regs`, and a read's first bit on `sdo`, one clk cycle after `sen` rises. Each later `sdo` bit follows one cycle after the corresponding `sck` fall. The bench changes inputs on falling clk edges and holds each serial level for two clk cycles. It samples outputs on the falling clk edge after the change, so every check sees the settled value. A bench model of the register bank and of the output shift register supplies the expected values, and each read is checked bit by bit while the next frame is shifted in.

// File: rtl/sras_pkg.sv
package sras_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 8;
    localparam int FRAME_W  = ADDR_W + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int RD_BIT   = 4;
    localparam int IDX_W    = ADDR_W - 1;
    localparam int MAX_REGS = 1 << IDX_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [IDX_W-1:0] reg_index(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:RD_BIT+1], a[RD_BIT-1:0]};
    endfunction
endpackage

// File: rtl/sras_edge.sv
module sras_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
        fall   = ~sig & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sras_rx.sv
module sras_rx
    import sras_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_rise,
    input  logic             sdi,
    input  logic             sen_rise,
    output logic             commit_wr,
    output logic             commit_rd,
    output frame_t           frame,
    output logic [CNT_W-1:0] bit_cnt
);
    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
    } rx_state_t;

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    rx_state_t st_d, st_q;
    logic      complete;

    always_comb begin
        st_d      = st_q;
        frame     = st_q.shreg;
        complete  = (st_q.cnt == CNT_FULL);
        commit_wr = sen_rise && complete && !frame.addr[RD_BIT];
        commit_rd = sen_rise && complete &&  frame.addr[RD_BIT];
        bit_cnt   = st_q.cnt;
        if (sen_rise) begin
            st_d.cnt = '0;
        end else if (sck_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdi};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sras_regfile.sv
module sras_regfile
    import sras_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);
    logic [DATA_W-1:0] bank [MAX_REGS];

    for (genvar i = 0; i < MAX_REGS; i++) begin : g_loc
        if (i < NUM_REGS) begin : g_live
            logic [DATA_W-1:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (wr_en && wr_idx == IDX_W'(i)) val_d = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end
            assign bank[i] = val_q;
            assign cfg_flat[i*DATA_W +: DATA_W] = val_q;
        end else begin : g_dead
            assign bank[i] = '0;
        end
    end

    assign rd_data = bank[rd_idx];
endmodule

// File: rtl/sras_tx.sv
module sras_tx
    import sras_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_fall,
    output logic              sdo,
    output logic              active
);
    localparam int LEFT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [LEFT_W-1:0] left;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        active = (st_q.left != '0);
        sdo    = active ? st_q.shreg[DATA_W-1] : 1'b0;
        if (load) begin
            st_d.shreg = load_data;
            st_d.left  = LEFT_W'(DATA_W);
        end else if (sck_fall && active) begin
            st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
            st_d.left  = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sras_top.sv
module sras_top
    import sras_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck,
    input  logic                       sdi,
    input  logic                       sen,
    input  logic                       oe_n,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    logic [1:0]        rise, fall;
    logic              sck_rise, sck_fall, sen_rise;
    logic              commit_wr, commit_rd, tx_active;
    frame_t            frame;
    logic [CNT_W-1:0]  rx_cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_data;

    sras_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({sen, sck}),
        .rise (rise),
        .fall (fall)
    );

    assign sck_rise = rise[0];
    assign sck_fall = fall[0];
    assign sen_rise = rise[1];

    sras_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sdi      (sdi),
        .sen_rise (sen_rise),
        .commit_wr(commit_wr),
        .commit_rd(commit_rd),
        .frame    (frame),
        .bit_cnt  (rx_cnt)
    );

    assign idx = reg_index(frame.addr);

    sras_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_wr),
        .wr_idx  (idx),
        .wr_data (frame.data),
        .rd_idx  (idx),
        .rd_data (rd_data),
        .cfg_flat(cfg_regs)
    );

    sras_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit_rd),
        .load_data(rd_data),
        .sck_fall (sck_fall),
        .sdo      (sdo),
        .active   (tx_active)
    );

    assign sdo_oe = ~oe_n;
endmodule

// File: rtl/sras_checker.sv
module sras_checker
    import sras_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sen_rise,
    input logic                       sck_fall,
    input logic                       commit_rd,
    input logic [CNT_W-1:0]           rx_cnt,
    input logic [DATA_W-1:0]          rd_data,
    input logic                       sdo,
    input logic                       tx_active,
    input logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    // R1, R7: idle serial output is low
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> sdo == 1'b0);

    // R4: a frame that was not 14 bits long never alters the bank
    a_r4_short_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_rise && rx_cnt != CNT_W'(FRAME_W)) |=> $stable(cfg_regs));

    // R4: every strobe restarts the bit count
    a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sen_rise |=> rx_cnt == '0);

    // R5: a read request leaves the bank untouched
    a_r5_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        commit_rd |=> $stable(cfg_regs));

    // R6: the selected byte's top bit is presented right after the commit
    a_r6_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_rd |=> (tx_active && sdo == $past(rd_data[DATA_W-1])));

    // R7: without a falling sck edge or a new load the output holds
    a_r7_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !commit_rd) |=> $stable(sdo));
endmodule

bind sras_top sras_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sen_rise (sen_rise),
    .sck_fall (sck_fall),
    .commit_rd(commit_rd),
    .rx_cnt   (rx_cnt),
    .rd_data  (rd_data),
    .sdo      (sdo),
    .tx_active(tx_active),
    .cfg_regs (cfg_regs)
);

// File: tb/tb_sras_top.sv
module tb_sras_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, sen = 1'b0, oe_n = 1'b1;
    logic sdo, sdo_oe;
    logic [NREG*8-1:0] cfg_regs;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] model [NREG];
    logic [7:0] exp_sh = 8'h00;
    int exp_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sras_top #(.NUM_REGS(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sen(sen),
        .oe_n(oe_n), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_regs(cfg_regs)
    );

    function automatic int idx_of(input logic [5:0] a);
        return int'({a[5], a[3:0]});
    endfunction

    function automatic logic exp_sdo();
        return (exp_left > 0) ? exp_sh[7] : 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < NREG; i++)
            chk(cfg_regs[i*8 +: 8] == model[i], req, 32'(cfg_regs[i*8 +: 8]), 32'(model[i]));
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one bit: rise samples b, sdi flips before the fall (R3), fall shifts readout
    task automatic send_bit(input logic b);
        sdi = b; tick(2);
        sck = 1'b1; tick(1);
        sdi = ~b; tick(1);
        sck = 1'b0; tick(1);
        if (exp_left > 0) begin
            exp_sh = {exp_sh[6:0], 1'b0};
            exp_left--;
        end
        chk(sdo == exp_sdo(), "R7 sdo after sck fall", 32'(sdo), 32'(exp_sdo()));
        tick(1);
    endtask

    task automatic send_frame(input logic [5:0] a, input logic [7:0] d, input int nbits);
        logic [13:0] fr;
        fr = {a, d};
        for (int i = 0; i < nbits; i++) send_bit(fr[13 - (i % 14)]);
        sen = 1'b1; tick(1);
        if (nbits == 14) begin
            if (!a[4]) model[idx_of(a)] = d;
            else begin
                exp_sh = model[idx_of(a)];
                exp_left = 8;
                chk(sdo == exp_sh[7], "R6 first read bit", 32'(sdo), 32'(exp_sh[7]));
            end
        end
        chk_bank(nbits == 14 ? (a[4] ? "R5 read leaves bank" : "R2 write commit")
                             : "R4 bad count discarded");
        tick(1);
        sen = 1'b0; tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk_bank("R1 reset bank");
        chk(sdo == 1'b0, "R1 reset sdo", 32'(sdo), 0);
        // R9 output enable
        chk(sdo_oe == 1'b0, "R9 oe_n high", 32'(sdo_oe), 0);
        oe_n = 1'b0; tick(1);
        chk(sdo_oe == 1'b1, "R9 oe_n low", 32'(sdo_oe), 1);
        // R2/R3 directed writes, extremes of the index
        send_frame(6'b000000, 8'hA5, 14);
        send_frame(6'b101111, 8'h3C, 14);
        send_frame(6'b100000, 8'hFF, 14);
        // R4 short and long frames
        send_frame(6'b000001, 8'h77, 13);
        send_frame(6'b000001, 8'h77, 15);
        // R5/R6/R7 read of index 31 while R8 a write shifts in
        send_frame(6'b111111, 8'hFF, 14);
        send_frame(6'b000010, 8'h81, 14);
        // back-to-back reads
        send_frame(6'b010000, 8'h00, 14);
        send_frame(6'b110000, 8'h5A, 14);
        send_frame(6'b000011, 8'h12, 8);
        chk(sdo == 1'b0, "R7 sdo idle after readout", 32'(sdo), 0);
        // random mix
        for (int k = 0; k < 250; k++) begin
            logic [5:0] a;
            logic [7:0] d;
            int nb;
            int r;
            a = 6'($urandom());
            d = 8'($urandom());
            r = int'($urandom_range(0, 9));
            nb = (r == 0) ? 13 : (r == 1) ? 15 : 14;
            send_frame(a, d, nb);
        end
        send_frame(6'b000000, 8'h00, 8);
        oe_n = 1'b1; tick(1);
        chk(sdo_oe == 1'b0, "R9 oe_n high again", 32'(sdo_oe), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule